// File: doc/BRIEF.md
# Microprogrammed Control Sequencer with Conditional Branch

This block is the sequencing half of a microprogrammed control unit. A micro-program counter addresses a small control store. In every cycle the block presents the control word stored at the current micro-address and then picks the next micro-address.

Each stored word carries its datapath enables and a two-bit next-address mode. The mode selects one of four actions: step to the following word, jump to the start of the microroutine chosen by the instruction opcode, jump to a target held in the word when the negative flag is clear, or return to the fetch routine. A word that raises the wait-for-memory enable freezes the counter until memory reports completion.

The store is filled in the RTL with two routines. The first is the instruction fetch routine at addresses 0 to 3. The second is a branch-if-negative routine that starts at address 25.

Top module: `useq_ctrl`

## Requirements
- R1: While rst_n is low the counter `upc` is 0, and the control word shown is the fetch word, 0x003F.
- R2: The fetch words are 0x003F at address 0, 0x03C0 at address 1 and 0x0C00 at address 2. Signal bit positions are: 0 pc drive, 1 memory-address load, 2 memory read, 3 select constant four, 4 ALU add, 5 Z load, 6 Z drive, 7 PC load, 8 Y load, 9 wait-for-memory, 10 memory-data drive, 11 instruction load, 12 offset drive, 13 select Y, 14 routine done.
- R3: A word whose mode is increment, and which is not stalled, moves `upc` to `upc+1` at the next edge. This holds whatever `opcode` and `n_flag` carry at the time.
- R4: When the current word has bit 9 set and `mem_done` is low, `upc` holds. When `mem_done` is high in that same cycle, the increment happens at that edge.
- R5: At address 3 (the map mode), `upc` goes to 25 when `opcode` equals 1. For any other opcode it goes to 0.
- R6: At address 25 (branch mode, target 0), `upc` goes to 0 when `n_flag` is 0 and to 26 when `n_flag` is 1. The word at address 25 is 0x0000.
- R7: The words at 26 and 27 are 0x3030 and 0x40C0.
- R8: A word in the end mode (address 27, which has bit 14 set) sends `upc` to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | OPW (4) | Opcode field of the instruction register |
| n_flag | input | 1 | Negative condition code |
| mem_done | input | 1 | Memory completion |
| upc | output | AW (5) | Current micro-address |
| ctrl_sig | output | 15 | Control word enables at `upc` |

## Verification
The wait-for-memory stall and the increment can both apply at address 1. The outcome then depends on `mem_done` in that cycle. The bench holds `mem_done` low for two cycles and expects `upc` to stay at 1. It then raises `mem_done` and expects 2 at the next edge. In a later fetch it raises `mem_done` on arrival, which must give no stall at all. The conditional branch is judged with `n_flag` both clear and set, and the opcode map with both the branch opcode and an unmapped opcode.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int NSIG = 15;

    localparam int S_PC_DRV  = 0;
    localparam int S_MAR_LD  = 1;
    localparam int S_MEM_RD  = 2;
    localparam int S_SEL4    = 3;
    localparam int S_ADD     = 4;
    localparam int S_Z_LD    = 5;
    localparam int S_Z_DRV   = 6;
    localparam int S_PC_LD   = 7;
    localparam int S_Y_LD    = 8;
    localparam int S_WAITMEM = 9;
    localparam int S_MDR_DRV = 10;
    localparam int S_IR_LD   = 11;
    localparam int S_OFS_DRV = 12;
    localparam int S_SELY    = 13;
    localparam int S_DONE    = 14;

    typedef enum logic [1:0] {
        NX_INC  = 2'd0,
        NX_MAP  = 2'd1,
        NX_BRNZ = 2'd2,
        NX_END  = 2'd3
    } nx_mode_e;
endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int AW        = 5,
    parameter int BRN_START = 25
) (
    input  logic [AW-1:0]   addr,
    output logic [NSIG-1:0] sig,
    output nx_mode_e        mode,
    output logic [AW-1:0]   tgt
);
    localparam logic [AW-1:0] A_BR0 = AW'(BRN_START);
    localparam logic [AW-1:0] A_BR1 = AW'(BRN_START + 1);
    localparam logic [AW-1:0] A_BR2 = AW'(BRN_START + 2);

    always_comb begin
        sig  = '0;
        mode = NX_END;
        tgt  = '0;
        if (addr == AW'(0)) begin
            sig[S_PC_DRV] = 1'b1;
            sig[S_MAR_LD] = 1'b1;
            sig[S_MEM_RD] = 1'b1;
            sig[S_SEL4]   = 1'b1;
            sig[S_ADD]    = 1'b1;
            sig[S_Z_LD]   = 1'b1;
            mode          = NX_INC;
        end else if (addr == AW'(1)) begin
            sig[S_Z_DRV]   = 1'b1;
            sig[S_PC_LD]   = 1'b1;
            sig[S_Y_LD]    = 1'b1;
            sig[S_WAITMEM] = 1'b1;
            mode           = NX_INC;
        end else if (addr == AW'(2)) begin
            sig[S_MDR_DRV] = 1'b1;
            sig[S_IR_LD]   = 1'b1;
            mode           = NX_INC;
        end else if (addr == AW'(3)) begin
            mode = NX_MAP;
        end else if (addr == A_BR0) begin
            mode = NX_BRNZ;
            tgt  = '0;
        end else if (addr == A_BR1) begin
            sig[S_OFS_DRV] = 1'b1;
            sig[S_SELY]    = 1'b1;
            sig[S_ADD]     = 1'b1;
            sig[S_Z_LD]    = 1'b1;
            mode           = NX_INC;
        end else if (addr == A_BR2) begin
            sig[S_Z_DRV] = 1'b1;
            sig[S_PC_LD] = 1'b1;
            sig[S_DONE]  = 1'b1;
            mode         = NX_END;
        end
    end
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int AW        = 5,
    parameter int OPW       = 4,
    parameter int OP_BRN    = 1,
    parameter int BRN_START = 25
) (
    input  logic [AW-1:0]  upc,
    input  nx_mode_e       mode,
    input  logic [AW-1:0]  tgt,
    input  logic           wait_mem,
    input  logic           mem_done,
    input  logic [OPW-1:0] opcode,
    input  logic           n_flag,
    output logic [AW-1:0]  nxt
);
    localparam logic [OPW-1:0] OPV = OPW'(OP_BRN);
    localparam logic [AW-1:0]  BRV = AW'(BRN_START);

    logic [AW-1:0] seq;
    logic [AW-1:0] start;

    assign seq   = upc + AW'(1);
    assign start = (opcode == OPV) ? BRV : '0;

    always_comb begin
        unique case (mode)
            NX_INC:  nxt = seq;
            NX_MAP:  nxt = start;
            NX_BRNZ: nxt = n_flag ? seq : tgt;
            default: nxt = '0;
        endcase
        if (wait_mem && !mem_done) nxt = upc;
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int AW        = 5,
    parameter int OPW       = 4,
    parameter int OP_BRN    = 1,
    parameter int BRN_START = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OPW-1:0]  opcode,
    input  logic            n_flag,
    input  logic            mem_done,
    output logic [AW-1:0]   upc,
    output logic [NSIG-1:0] ctrl_sig
);
    typedef struct packed {
        logic [AW-1:0] upc;
    } st_t;

    st_t           st_d, st_q;
    nx_mode_e      mode;
    logic [AW-1:0] tgt;
    logic [AW-1:0] nxt;

    useq_store #(.AW(AW), .BRN_START(BRN_START)) u_store (
        .addr (st_q.upc),
        .sig  (ctrl_sig),
        .mode (mode),
        .tgt  (tgt)
    );

    useq_next #(.AW(AW), .OPW(OPW), .OP_BRN(OP_BRN), .BRN_START(BRN_START)) u_next (
        .upc      (st_q.upc),
        .mode     (mode),
        .tgt      (tgt),
        .wait_mem (ctrl_sig[S_WAITMEM]),
        .mem_done (mem_done),
        .opcode   (opcode),
        .n_flag   (n_flag),
        .nxt      (nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upc = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upc = st_q.upc;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
    import useq_pkg::*;
#(
    parameter int AW        = 5,
    parameter int OPW       = 4,
    parameter int OP_BRN    = 1,
    parameter int BRN_START = 25
) (
    input logic            clk,
    input logic            rst_n,
    input logic [OPW-1:0]  opcode,
    input logic            n_flag,
    input logic            mem_done,
    input logic [AW-1:0]   upc,
    input logic [NSIG-1:0] ctrl_sig
);
    always_comb begin
        if (!rst_n) begin
            assert_reset_state_R1: assert (upc == '0 && ctrl_sig == NSIG'(16'h003F));
        end
    end

    assert_fetch_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == AW'(1)) |-> (ctrl_sig == NSIG'(16'h03C0)));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == AW'(0)) |=> (upc == AW'(1)));

    assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_sig[S_WAITMEM] && !mem_done) |=> $stable(upc));

    assert_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == AW'(3) && opcode == OPW'(OP_BRN)) |=> (upc == AW'(BRN_START)));

    assert_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == AW'(BRN_START) && !n_flag) |=> (upc == '0));

    assert_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_sig[S_DONE] |=> (upc == '0));
endmodule

bind useq_ctrl useq_ctrl_chk #(
    .AW(AW), .OPW(OPW), .OP_BRN(OP_BRN), .BRN_START(BRN_START)
) u_chk (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .n_flag(n_flag),
    .mem_done(mem_done), .upc(upc), .ctrl_sig(ctrl_sig)
);

// File: tb/useq_ctrl_tb.sv
`timescale 1ns/1ps
module useq_ctrl_tb;
    localparam int AW  = 5;
    localparam int OPW = 4;
    localparam int NS  = 15;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [OPW-1:0] opcode = '0;
    logic           n_flag = 1'b0;
    logic           mem_done = 1'b0;
    logic [AW-1:0]  upc;
    logic [NS-1:0]  ctrl_sig;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_run = 1'b0;

    typedef struct {
        logic [AW-1:0] upc;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    useq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .n_flag(n_flag),
        .mem_done(mem_done), .upc(upc), .ctrl_sig(ctrl_sig)
    );

    // Control words taken from the requirements R2, R6 and R7
    function automatic logic [NS-1:0] word_at(input logic [AW-1:0] a);
        case (a)
            5'd0:    return 15'h003F;
            5'd1:    return 15'h03C0;
            5'd2:    return 15'h0C00;
            5'd26:   return 15'h3030;
            5'd27:   return 15'h40C0;
            default: return 15'h0000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [OPW-1:0] op, input logic n, input logic md,
                         input logic [AW-1:0] exp_upc, input string tag);
        exp_t e;
        @(negedge clk);
        opcode   = op;
        n_flag   = n;
        mem_done = md;
        @(posedge clk);
        e.upc = exp_upc;
        e.tag = tag;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " upc"}, 32'(upc), 32'(e.upc));
            check({e.tag, " word"}, 32'(ctrl_sig), 32'(word_at(e.upc)));
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset upc", 32'(upc), 32'd0);
        check("R1 reset word", 32'(ctrl_sig), 32'h003F);
        rst_n = 1'b1;

        drive(4'd0, 1'b1, 1'b0, 5'd1,  "R3 0->1 with N set");
        drive(4'd0, 1'b0, 1'b0, 5'd1,  "R4 stall");
        drive(4'd7, 1'b1, 1'b0, 5'd1,  "R4 stall again");
        drive(4'd0, 1'b0, 1'b1, 5'd2,  "R4 release");
        drive(4'd1, 1'b1, 1'b0, 5'd3,  "R3 2->3");
        drive(4'd1, 1'b1, 1'b0, 5'd25, "R5 map branch op");
        drive(4'd0, 1'b1, 1'b0, 5'd26, "R6 N set falls through");
        drive(4'd0, 1'b0, 1'b0, 5'd27, "R7 26->27");
        drive(4'd0, 1'b0, 1'b0, 5'd0,  "R8 end");

        drive(4'd0, 1'b0, 1'b1, 5'd1,  "R3 refetch");
        drive(4'd0, 1'b0, 1'b1, 5'd2,  "R4 done on arrival");
        drive(4'd0, 1'b0, 1'b0, 5'd3,  "R3 2->3 again");
        drive(4'd1, 1'b0, 1'b0, 5'd25, "R5 map again");
        drive(4'd0, 1'b0, 1'b0, 5'd0,  "R6 N clear taken");

        drive(4'd0, 1'b0, 1'b1, 5'd1,  "R3 fetch 3");
        drive(4'd0, 1'b0, 1'b1, 5'd2,  "R4 no stall");
        drive(4'd0, 1'b0, 1'b0, 5'd3,  "R3 to map");
        drive(4'd5, 1'b0, 1'b0, 5'd0,  "R5 unmapped opcode");
        drive(4'd0, 1'b0, 1'b0, 5'd1,  "R2 fetch word again");

        @(negedge clk);
        @(negedge clk);
        done_run = 1'b1;
    end

    initial begin
        fork
            wait (done_run);
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule